// File: doc/BRIEF.md
# Sample Record Filter

This block sits at the end of a statistical profiling pipeline and makes the final keep-or-drop decision for each finished sample record. Every record arrives in one cycle, marked by a valid strobe, and carries an event bit vector, an operation class and the latency counted from the moment sampling started on that operation. The latency is the total time since the sample began, not only the execute portion.

Three configuration inputs shape the decision. The first is a required-event mask. The second is a set of per-class enables for loads, stores and branches. The third is a minimum latency. One cycle after the strobe, the block raises exactly one of two pulses, keep or discard. A running count of kept records is maintained alongside. A discarded record causes no further output activity beyond its discard pulse.

Top module: `sample_rec_filter`

## Requirements
- R1: A record is kept only if every filterable event bit set in the mask is also set in the record's event vector. The filterable positions are bit 1 (retired), bit 3 (L1 data refill), bit 5 (TLB refill), bit 7 (mispredict) and bit 11 (misaligned).
- R2: Mask bits at positions other than 1, 3, 5, 7 and 11 have no effect on the decision.
- R3: The operation class is encoded as 0 other, 1 load, 2 store, 3 branch. When one or more class enables are set, a record passes only if its class matches an enabled class.
- R4: With all three class enables clear, records of every class pass the class check.
- R5: A record whose latency is below the programmed minimum is discarded. A latency equal to the minimum passes.
- R6: For each strobed record, exactly one of keep or discard is high for one cycle, in the cycle after the strobe. The two pulses are never high together.
- R7: Neither pulse is raised in a cycle that did not follow a record strobe.
- R8: The kept counter rises by one with each keep pulse and is unchanged otherwise. When the saturation option is on (the default), it holds at its maximum value.
- R9: After reset both pulses are low and the kept counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_evt_mask | input | EVT_W | Required-event mask |
| cfg_load_en | input | 1 | Pass loads |
| cfg_store_en | input | 1 | Pass stores |
| cfg_branch_en | input | 1 | Pass branches |
| cfg_min_lat | input | LAT_W | Minimum total latency |
| rec_valid | input | 1 | Record strobe |
| rec_events | input | EVT_W | Record event vector |
| rec_op | input | 2 | Record operation class |
| rec_latency | input | LAT_W | Record total latency |
| keep_o | output | 1 | Keep pulse |
| discard_o | output | 1 | Discard pulse |
| kept_count | output | CNT_W | Count of kept records |

## Verification
The hardest state to reach from the ports is the kept counter sitting at its ceiling while further records keep passing. The bench builds the filter with a narrow counter and streams back-to-back passing records well past the limit, so the ceiling is reached within a few dozen cycles. Boundary latencies (one below, equal to and one above the minimum) are also driven. Masks made up only of non-filterable bits are driven to show that they leave the decision unchanged.

// File: rtl/srf_pkg.sv
package srf_pkg;
   typedef enum logic [1:0] {
      OP_OTHER  = 2'd0,
      OP_LOAD   = 2'd1,
      OP_STORE  = 2'd2,
      OP_BRANCH = 2'd3
   } op_class_e;

   localparam int unsigned N_FILT_CLASSES = 3;

   // Positions of the events that may take part in filtering
   localparam int unsigned EVT_RETIRED    = 1;
   localparam int unsigned EVT_L1D_REFILL = 3;
   localparam int unsigned EVT_TLB_REFILL = 5;
   localparam int unsigned EVT_MISPRED    = 7;
   localparam int unsigned EVT_MISALIGN   = 11;
   localparam int unsigned EVT_MIN_W      = EVT_MISALIGN + 1;

   function automatic logic [63:0] filterable_bits();
      logic [63:0] v;
      v = '0;
      v[EVT_RETIRED]    = 1'b1;
      v[EVT_L1D_REFILL] = 1'b1;
      v[EVT_TLB_REFILL] = 1'b1;
      v[EVT_MISPRED]    = 1'b1;
      v[EVT_MISALIGN]   = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/srf_event_match.sv
module srf_event_match
   import srf_pkg::*;
#(
   parameter int unsigned EVT_W     = 16,
   parameter bit          MATCH_ALL = 1'b1
) (
   input  logic [EVT_W-1:0] mask_i,
   input  logic [EVT_W-1:0] events_i,
   output logic             ok_o
);
   localparam logic [63:0]      FILT_ALL = filterable_bits();
   localparam logic [EVT_W-1:0] FILT     = FILT_ALL[EVT_W-1:0];

   if (EVT_W < EVT_MIN_W) begin : g_width_chk
      $error("srf_event_match: EVT_W too small for filterable events");
   end

   logic [EVT_W-1:0] mask_eff;
   logic [EVT_W-1:0] hit;

   always_comb begin
      mask_eff = mask_i & FILT;
      hit      = events_i & mask_eff;
   end

   if (MATCH_ALL) begin : g_all
      always_comb ok_o = (hit == mask_eff);
   end else begin : g_any
      always_comb ok_o = (mask_eff == '0) || (hit != '0);
   end
endmodule

// File: rtl/srf_type_match.sv
module srf_type_match
   import srf_pkg::*;
(
   input  logic [N_FILT_CLASSES-1:0] en_i,
   input  logic [1:0]                op_i,
   output logic                      ok_o
);
   localparam logic [1:0] CLASS_CODE [N_FILT_CLASSES] = '{OP_LOAD, OP_STORE, OP_BRANCH};

   logic [N_FILT_CLASSES-1:0] hit;

   for (genvar i = 0; i < N_FILT_CLASSES; i++) begin : g_cls
      always_comb hit[i] = en_i[i] && (op_i == CLASS_CODE[i]);
   end

   always_comb ok_o = (en_i == '0) || (hit != '0);
endmodule

// File: rtl/srf_latency_gate.sv
module srf_latency_gate #(
   parameter int unsigned LAT_W = 12
) (
   input  logic [LAT_W-1:0] min_i,
   input  logic [LAT_W-1:0] lat_i,
   output logic             ok_o
);
   if (LAT_W < 1) begin : g_width_chk
      $error("srf_latency_gate: LAT_W must be at least 1");
   end

   always_comb ok_o = (lat_i >= min_i);
endmodule

// File: rtl/srf_pass_counter.sv
module srf_pass_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2) begin : g_width_chk
      $error("srf_pass_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] nxt;

   if (SATURATE) begin : g_sat
      always_comb nxt = (count_o == CNT_MAX) ? count_o : count_o + 1'b1;
   end else begin : g_wrap
      always_comb nxt = count_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_o <= '0;
      else if (inc_i) count_o <= nxt;
   end
endmodule

// File: rtl/sample_rec_filter.sv
module sample_rec_filter
   import srf_pkg::*;
#(
   parameter int unsigned EVT_W     = 16,
   parameter int unsigned LAT_W     = 12,
   parameter int unsigned CNT_W     = 16,
   parameter bit          MATCH_ALL = 1'b1,
   parameter bit          SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] cfg_evt_mask,
   input  logic             cfg_load_en,
   input  logic             cfg_store_en,
   input  logic             cfg_branch_en,
   input  logic [LAT_W-1:0] cfg_min_lat,
   input  logic             rec_valid,
   input  logic [EVT_W-1:0] rec_events,
   input  logic [1:0]       rec_op,
   input  logic [LAT_W-1:0] rec_latency,
   output logic             keep_o,
   output logic             discard_o,
   output logic [CNT_W-1:0] kept_count
);
   logic evt_ok, type_ok, lat_ok, pass;
   logic [N_FILT_CLASSES-1:0] cls_en;

   always_comb cls_en = {cfg_branch_en, cfg_store_en, cfg_load_en};

   srf_event_match #(.EVT_W(EVT_W), .MATCH_ALL(MATCH_ALL)) evt_i (
      .mask_i   (cfg_evt_mask),
      .events_i (rec_events),
      .ok_o     (evt_ok)
   );

   srf_type_match type_i (
      .en_i (cls_en),
      .op_i (rec_op),
      .ok_o (type_ok)
   );

   srf_latency_gate #(.LAT_W(LAT_W)) lat_i (
      .min_i (cfg_min_lat),
      .lat_i (rec_latency),
      .ok_o  (lat_ok)
   );

   always_comb pass = evt_ok && type_ok && lat_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_o    <= 1'b0;
         discard_o <= 1'b0;
      end else begin
         keep_o    <= rec_valid &&  pass;
         discard_o <= rec_valid && !pass;
      end
   end

   srf_pass_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (rec_valid && pass),
      .count_o (kept_count)
   );
endmodule

// File: rtl/sample_rec_filter_chk.sv
module sample_rec_filter_chk #(
   parameter int unsigned EVT_W    = 16,
   parameter int unsigned LAT_W    = 12,
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LAT_W-1:0] cfg_min_lat,
   input logic             rec_valid,
   input logic [LAT_W-1:0] rec_latency,
   input logic             keep_o,
   input logic             discard_o,
   input logic [CNT_W-1:0] kept_count
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R6
   pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(keep_o && discard_o));

   // R6
   record_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> (keep_o || discard_o));

   // R7
   no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_valid |=> !(keep_o || discard_o));

   // R5
   short_latency_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && (rec_latency < cfg_min_lat)) |=> discard_o);

   // R8
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !keep_o |-> $stable(kept_count));

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      keep_o |-> ((kept_count == $past(kept_count) + 1'b1) ||
                  (SATURATE && ($past(kept_count) == CMAX) && (kept_count == CMAX))));
endmodule

bind sample_rec_filter sample_rec_filter_chk #(
   .EVT_W(EVT_W), .LAT_W(LAT_W), .CNT_W(CNT_W), .SATURATE(SATURATE)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_min_lat (cfg_min_lat),
   .rec_valid   (rec_valid),
   .rec_latency (rec_latency),
   .keep_o      (keep_o),
   .discard_o   (discard_o),
   .kept_count  (kept_count)
);

// File: tb/sample_rec_filter_tb_top.sv
module sample_rec_filter_tb_top;
   localparam int unsigned EVT_W = 16;
   localparam int unsigned LAT_W = 12;
   localparam int unsigned CNT_W = 5;
   localparam logic [EVT_W-1:0] FILTERABLE = 16'h08AA;
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [EVT_W-1:0] cfg_evt_mask = '0;
   logic cfg_load_en = 1'b0, cfg_store_en = 1'b0, cfg_branch_en = 1'b0;
   logic [LAT_W-1:0] cfg_min_lat = '0;
   logic rec_valid = 1'b0;
   logic [EVT_W-1:0] rec_events = '0;
   logic [1:0] rec_op = '0;
   logic [LAT_W-1:0] rec_latency = '0;
   logic keep_o, discard_o;
   logic [CNT_W-1:0] kept_count;

   always #10 clk = ~clk;

   sample_rec_filter #(.EVT_W(EVT_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_evt_mask(cfg_evt_mask),
      .cfg_load_en(cfg_load_en), .cfg_store_en(cfg_store_en),
      .cfg_branch_en(cfg_branch_en), .cfg_min_lat(cfg_min_lat),
      .rec_valid(rec_valid), .rec_events(rec_events), .rec_op(rec_op),
      .rec_latency(rec_latency), .keep_o(keep_o), .discard_o(discard_o),
      .kept_count(kept_count)
   );

   typedef struct {
      logic  keep;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int errors = 0;
   int exp_count = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   function automatic bit model(input logic [EVT_W-1:0] ev, input logic [1:0] op,
                                input logic [LAT_W-1:0] lat);
      logic [EVT_W-1:0] m;
      bit ty;
      m  = cfg_evt_mask & FILTERABLE;
      ty = !(cfg_load_en || cfg_store_en || cfg_branch_en) ||
           (cfg_load_en && op == 2'd1) || (cfg_store_en && op == 2'd2) ||
           (cfg_branch_en && op == 2'd3);
      return ((ev & m) == m) && ty && (lat >= cfg_min_lat);
   endfunction

   // Driver: called just after a negedge; record is sampled at the next posedge
   task automatic send(input logic [EVT_W-1:0] ev, input logic [1:0] op,
                       input logic [LAT_W-1:0] lat, input string tag);
      exp_t e;
      e.keep = model(ev, op, lat);
      e.tag  = tag;
      exp_q.push_back(e);
      rec_valid = 1'b1; rec_events = ev; rec_op = op; rec_latency = lat;
      @(negedge clk); #1;
      rec_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   // Monitor: compares at each negedge
   always @(negedge clk) begin
      if (mon_on) begin
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.keep && exp_count < int'(CMAX)) exp_count++;
            check(keep_o == e.keep, e.tag, "keep", keep_o, e.keep);
            check(discard_o == !e.keep, "R6", "discard", discard_o, !e.keep);
            check(kept_count == exp_count[CNT_W-1:0], "R8", "count", kept_count, exp_count);
         end else begin
            check(!keep_o && !discard_o, "R7", "idle pulse", {keep_o, discard_o}, 0);
            check(kept_count == exp_count[CNT_W-1:0], "R8", "count idle", kept_count, exp_count);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9
      check(!keep_o && !discard_o, "R9", "pulses in reset", {keep_o, discard_o}, 0);
      check(kept_count == 0, "R9", "count in reset", kept_count, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      mon_on = 1'b1;

      // R4: no class enables, everything passes
      send(16'h0000, 2'd0, 0, "R4");
      send(16'h0000, 2'd1, 5, "R4");
      send(16'h0000, 2'd2, 5, "R4");
      send(16'h0000, 2'd3, 5, "R4");
      idle(2);

      // R1: required events
      cfg_evt_mask = 16'h0002;
      send(16'h0000, 2'd0, 1, "R1");
      send(16'h0002, 2'd0, 1, "R1");
      cfg_evt_mask = 16'h0088;
      send(16'h0080, 2'd3, 1, "R1");
      send(16'h0008, 2'd1, 1, "R1");
      send(16'h0888, 2'd1, 1, "R1");
      cfg_evt_mask = 16'h0800;
      send(16'h0000, 2'd2, 1, "R1");
      send(16'hFFFF, 2'd2, 1, "R1");
      idle(1);

      // R2: non-filterable mask bits ignored
      cfg_evt_mask = 16'hF755;
      send(16'h0000, 2'd0, 1, "R2");
      cfg_evt_mask = 16'hF757;
      send(16'h0001, 2'd0, 1, "R2");
      send(16'h0002, 2'd0, 1, "R2");
      cfg_evt_mask = '0;
      idle(1);

      // R3: class filters
      cfg_load_en = 1'b1;
      send(0, 2'd1, 1, "R3");
      send(0, 2'd2, 1, "R3");
      send(0, 2'd3, 1, "R3");
      send(0, 2'd0, 1, "R3");
      cfg_branch_en = 1'b1;
      send(0, 2'd3, 1, "R3");
      send(0, 2'd2, 1, "R3");
      cfg_load_en = 1'b0; cfg_branch_en = 1'b0; cfg_store_en = 1'b1;
      send(0, 2'd2, 1, "R3");
      send(0, 2'd1, 1, "R3");
      cfg_store_en = 1'b0;
      idle(2);

      // R5: latency threshold boundaries
      cfg_min_lat = 12'd10;
      send(0, 2'd0, 12'd9, "R5");
      send(0, 2'd0, 12'd10, "R5");
      send(0, 2'd0, 12'd11, "R5");
      send(0, 2'd0, 12'd0, "R5");
      cfg_min_lat = 12'hFFF;
      send(0, 2'd0, 12'hFFE, "R5");
      send(0, 2'd0, 12'hFFF, "R5");
      cfg_min_lat = '0;
      idle(3);

      // R8: drive counter to saturation with back-to-back keeps
      for (int i = 0; i < 40; i++) send(0, 2'd1, 3, "R8");
      send(16'h0000, 2'd1, 3, "R8");
      idle(3);
      check(kept_count == CMAX, "R8", "saturated", kept_count, CMAX);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule